// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two component predictors side by side. The first is a per-address table of 2-bit saturating counters. The second is a table of the same counters indexed by the branch address XORed with a global history of recent branch directions. A third table of 2-bit counters, the chooser, learns for each slot which of the two components has been more reliable. The final prediction is taken from the component that the chooser selects.

The fetch stage presents the low bits of a branch address. In the same cycle it receives the final direction, the history value in use before this branch, and a packed snapshot. The snapshot holds that history, all three table indices and both component predictions. When the fetch is marked valid, the global history is shifted at once with the predicted direction. The counters are left untouched until the branch resolves.

At resolution the pipeline hands the snapshot back together with the real direction and a mispredict flag. All table writes use the indices carried in the snapshot. On a mispredict the history is rebuilt from the snapshot's history value with the real outcome shifted in. This discards every speculative shift made after that branch.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every counter of all three tables holds 2'b10 and the global history is zero, so any fetch predicts taken and reports history 0.
- R2: The bimodal component is a table of 2-bit saturating counters indexed by f_pc[BIM_W-1:0]. Its prediction is the counter's top bit. A taken resolution increments the counter up to 11, and a not-taken resolution decrements it down to 00.
- R3: The gshare component is a table of 2-bit saturating counters indexed by f_pc[HIST_W-1:0] XOR the global history, and predicts with the counter's top bit.
- R4: A chooser counter with its top bit set selects the bimodal prediction, and otherwise the gshare prediction is selected. The chooser is indexed by f_pc[CHO_W-1:0] when CHO_BY_HIST is 0, and by history[CHO_W-1:0] when it is 1.
- R5: At resolution the chooser counter increments (saturating at 11) when only the bimodal component was right. It decrements (saturating at 00) when only the gshare component was right. It is unchanged when both were right or both were wrong.
- R6: A valid fetch shifts the history left by one with the final predicted direction entering bit 0, effective from the next cycle.
- R7: A valid resolve with r_mispredict set loads the history with {snapshot history[HIST_W-2:0], r_taken}. This has priority over a fetch in the same cycle.
- R8: Counters change only on a valid resolve, and only at the indices carried in r_snap. Fetches never modify any counter.
- R9: Snapshot layout, LSB first: bit 0 is the gshare prediction, bit 1 is the bimodal prediction, then the chooser index (CHO_W bits), the gshare index (HIST_W bits), the bimodal index (BIM_W bits), and the history (HIST_W bits) at the top. f_hist equals that history field.
- R10: With no valid fetch and no mispredicting resolve, the history holds its value. A resolve without mispredict does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Fetch lookup is real; advances the history |
| f_pc | input | HIST_W | Low bits of the branch address |
| f_pred | output | 1 | Final predicted direction (1 = taken) |
| f_hist | output | HIST_W | Global history used by this lookup |
| f_snap | output | SNAP_W | Snapshot to carry to resolution |
| r_valid | input | 1 | A branch resolves this cycle |
| r_snap | input | SNAP_W | Snapshot captured at that branch's fetch |
| r_taken | input | 1 | Actual direction |
| r_mispredict | input | 1 | Final prediction was wrong; repair history |

## Verification
The hardest situation to reach from the ports is one where the chooser favours gshare while the two components disagree. That needs a chooser slot driven down and a gshare counter driven the opposite way from its bimodal twin, and every fresh counter starts out predicting taken. The bench gets there with resolves carrying hand-built snapshots. These aim updates at chosen indices without any fetch. History repairs are used to set an exact history value. A fetch with f_valid low then reads the outputs without moving the history. The same method shows the history-indexed chooser variant selecting a different component from the address-indexed one.

// File: rtl/tourney_pkg.sv
package tourney_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_RESET = 2'b10;

    // Saturating step of a two-bit counter.
    function automatic ctr2_t ctr2_step(ctr2_t c, logic up);
        ctr2_t r;
        if (up) r = (c == 2'b11) ? c : c + 2'b01;
        else    r = (c == 2'b00) ? c : c - 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/tourney_ctr_table.sv
module tourney_ctr_table
    import tourney_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t tbl_q [DEPTH];
    ctr2_t tbl_d [DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (upd_en) begin
            tbl_d[upd_idx] = ctr2_step(tbl_q[upd_idx], upd_up);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= CTR_RESET;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ctr = tbl_q[rd_idx];

endmodule

// File: rtl/tourney_ghist.sv
module tourney_ghist #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              spec_dir,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_base,
    input  logic              fix_dir,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } gh_state_t;

    gh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fix_en) begin
            // repair wins: a same-cycle fetch lies on the wrong path
            st_d.hist = {fix_base[HIST_W-2:0], fix_dir};
        end else if (spec_en) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], spec_dir};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist = st_q.hist;

endmodule

// File: rtl/tourney_index.sv
module tourney_index #(
    parameter int HIST_W      = 10,
    parameter int BIM_W       = 8,
    parameter int CHO_W       = 8,
    parameter bit CHO_BY_HIST = 1'b0
) (
    input  logic [HIST_W-1:0] pc,
    input  logic [HIST_W-1:0] hist,
    output logic [BIM_W-1:0]  bim_idx,
    output logic [HIST_W-1:0] gsh_idx,
    output logic [CHO_W-1:0]  cho_idx
);
    assign bim_idx = pc[BIM_W-1:0];
    assign gsh_idx = pc ^ hist;

    generate
        if (CHO_BY_HIST) begin : g_cho_hist
            assign cho_idx = hist[CHO_W-1:0];
        end else begin : g_cho_pc
            assign cho_idx = pc[CHO_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
    import tourney_pkg::*;
#(
    parameter int HIST_W      = 10,
    parameter int BIM_W       = 8,
    parameter int CHO_W       = 8,
    parameter bit CHO_BY_HIST = 1'b0,
    localparam int SNAP_W     = 2 * HIST_W + BIM_W + CHO_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_valid,
    input  logic [HIST_W-1:0] f_pc,
    output logic              f_pred,
    output logic [HIST_W-1:0] f_hist,
    output logic [SNAP_W-1:0] f_snap,
    input  logic              r_valid,
    input  logic [SNAP_W-1:0] r_snap,
    input  logic              r_taken,
    input  logic              r_mispredict
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [BIM_W-1:0]  bim_idx;
        logic [HIST_W-1:0] gsh_idx;
        logic [CHO_W-1:0]  cho_idx;
        logic              bim_dir;
        logic              gsh_dir;
    } snap_t;

    typedef struct packed {
        logic bim_ok;
        logic gsh_ok;
        logic cho_en;
        logic fix_en;
    } res_ctl_t;

    logic [HIST_W-1:0] hist_q;
    logic [BIM_W-1:0]  f_bim_idx;
    logic [HIST_W-1:0] f_gsh_idx;
    logic [CHO_W-1:0]  f_cho_idx;
    ctr2_t             bim_ctr, gsh_ctr, cho_ctr;
    snap_t             fs, rs;
    res_ctl_t          rc;
    logic              pred;

    tourney_index #(
        .HIST_W(HIST_W), .BIM_W(BIM_W), .CHO_W(CHO_W), .CHO_BY_HIST(CHO_BY_HIST)
    ) u_index (
        .pc(f_pc), .hist(hist_q),
        .bim_idx(f_bim_idx), .gsh_idx(f_gsh_idx), .cho_idx(f_cho_idx)
    );

    assign rs = snap_t'(r_snap);

    always_comb begin
        pred       = cho_ctr[1] ? bim_ctr[1] : gsh_ctr[1];
        fs.hist    = hist_q;
        fs.bim_idx = f_bim_idx;
        fs.gsh_idx = f_gsh_idx;
        fs.cho_idx = f_cho_idx;
        fs.bim_dir = bim_ctr[1];
        fs.gsh_dir = gsh_ctr[1];

        rc.bim_ok = (rs.bim_dir == r_taken);
        rc.gsh_ok = (rs.gsh_dir == r_taken);
        rc.cho_en = r_valid && (rc.bim_ok != rc.gsh_ok);
        rc.fix_en = r_valid && r_mispredict;
    end

    tourney_ctr_table #(.IDX_W(BIM_W)) u_bim (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_bim_idx), .rd_ctr(bim_ctr),
        .upd_en(r_valid), .upd_idx(rs.bim_idx), .upd_up(r_taken)
    );

    tourney_ctr_table #(.IDX_W(HIST_W)) u_gsh (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_gsh_idx), .rd_ctr(gsh_ctr),
        .upd_en(r_valid), .upd_idx(rs.gsh_idx), .upd_up(r_taken)
    );

    tourney_ctr_table #(.IDX_W(CHO_W)) u_cho (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_cho_idx), .rd_ctr(cho_ctr),
        .upd_en(rc.cho_en), .upd_idx(rs.cho_idx), .upd_up(rc.bim_ok)
    );

    tourney_ghist #(.HIST_W(HIST_W)) u_ghist (
        .clk(clk), .rst_n(rst_n),
        .spec_en(f_valid), .spec_dir(pred),
        .fix_en(rc.fix_en), .fix_base(rs.hist), .fix_dir(r_taken),
        .hist(hist_q)
    );

    assign f_pred = pred;
    assign f_hist = hist_q;
    assign f_snap = fs;

endmodule

// File: rtl/tourney_predictor_chk.sv
module tourney_predictor_chk #(
    parameter int HIST_W = 10,
    parameter int SNAP_W = 38
) (
    input logic              clk,
    input logic              rst_n,
    input logic              f_valid,
    input logic              f_pred,
    input logic [HIST_W-1:0] f_hist,
    input logic [SNAP_W-1:0] f_snap,
    input logic              r_valid,
    input logic [SNAP_W-1:0] r_snap,
    input logic              r_taken,
    input logic              r_mispredict
);
    logic [HIST_W-1:0] shift_exp;
    logic [HIST_W-1:0] fix_exp;
    logic              repair;

    assign shift_exp = {f_hist[HIST_W-2:0], f_pred};
    assign fix_exp   = {r_snap[SNAP_W-2:SNAP_W-HIST_W], r_taken};
    assign repair    = r_valid && r_mispredict;

    p_fetch_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid && !repair |=> f_hist == $past(shift_exp));

    p_repair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        repair |=> f_hist == $past(fix_exp));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !f_valid && !repair |=> $stable(f_hist));

    p_agree_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        f_snap[1] == f_snap[0] |-> f_pred == f_snap[0]);

endmodule

bind tourney_predictor tourney_predictor_chk #(
    .HIST_W(HIST_W), .SNAP_W(SNAP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pred(f_pred),
    .f_hist(f_hist), .f_snap(f_snap), .r_valid(r_valid), .r_snap(r_snap),
    .r_taken(r_taken), .r_mispredict(r_mispredict)
);

// File: tb/sim_tourney_predictor.sv
module sim_tourney_predictor;
    localparam int HW = 10;
    localparam int BW = 8;
    localparam int CW = 8;
    localparam int SW = 2 * HW + BW + CW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_valid = 1'b0;
    logic [HW-1:0] f_pc = '0;
    logic r_valid = 1'b0;
    logic [SW-1:0] r_snap = '0;
    logic r_taken = 1'b0;
    logic r_mispredict = 1'b0;

    logic f_pred, f_pred1;
    logic [HW-1:0] f_hist, f_hist1;
    logic [SW-1:0] f_snap, f_snap1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tourney_predictor u0 (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc),
        .f_pred(f_pred), .f_hist(f_hist), .f_snap(f_snap),
        .r_valid(r_valid), .r_snap(r_snap), .r_taken(r_taken),
        .r_mispredict(r_mispredict)
    );

    tourney_predictor #(.CHO_BY_HIST(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc),
        .f_pred(f_pred1), .f_hist(f_hist1), .f_snap(f_snap1),
        .r_valid(r_valid), .r_snap(r_snap), .r_taken(r_taken),
        .r_mispredict(r_mispredict)
    );

    typedef struct packed {
        logic [HW-1:0] pc;
        logic          taken;
        logic          e_pred;
        logic          e_bim;
        logic          e_gsh;
        logic [HW-1:0] e_hist;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{10'h004, 1'b0, 1'b1, 1'b1, 1'b1, 10'd0},
        '{10'h004, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0},
        '{10'h004, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0},
        '{10'h004, 1'b1, 1'b0, 1'b0, 1'b0, 10'd0},
        '{10'h004, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1},
        '{10'h004, 1'b1, 1'b0, 1'b0, 1'b1, 10'd2},
        '{10'h004, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5},
        '{10'h004, 1'b1, 1'b1, 1'b1, 1'b1, 10'd11},
        '{10'h004, 1'b0, 1'b1, 1'b1, 1'b1, 10'd23},
        '{10'h008, 1'b0, 1'b1, 1'b1, 1'b1, 10'd46}
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] mk(logic [HW-1:0] h, logic [BW-1:0] bi,
                                         logic [HW-1:0] gi, logic [CW-1:0] ci,
                                         logic bp, logic gp);
        return {h, bi, gi, ci, bp, gp};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; f_valid = 1'b0; r_valid = 1'b0; r_mispredict = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic resolve(logic [SW-1:0] s, logic tk, logic mis);
        @(negedge clk);
        f_valid = 1'b0; r_valid = 1'b1; r_snap = s; r_taken = tk; r_mispredict = mis;
        @(negedge clk);
        r_valid = 1'b0; r_mispredict = 1'b0;
    endtask

    task automatic peek(logic [HW-1:0] pc);
        @(negedge clk);
        f_valid = 1'b0; f_pc = pc;
        #1;
    endtask

    task automatic fetch(logic [HW-1:0] pc, output logic [SW-1:0] s, output logic p);
        @(negedge clk);
        f_valid = 1'b1; f_pc = pc;
        #1;
        s = f_snap; p = f_pred;
        @(negedge clk);
        f_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] s;
        logic p;

        // R1: reset state
        do_reset();
        peek(10'h000); chk("R1 hist", f_hist, 0); chk("R1 pred 000", f_pred, 1);
        peek(10'h3FF); chk("R1 pred 3FF", f_pred, 1);
        peek(10'h155); chk("R1 pred 155", f_pred, 1);

        // R2..R7 vector walk, each branch resolved right after its fetch
        for (int i = 0; i < 10; i++) begin
            fetch(VECS[i].pc, s, p);
            chk($sformatf("R4 vec%0d pred", i), p, VECS[i].e_pred);
            chk($sformatf("R2 vec%0d bim", i), s[1], VECS[i].e_bim);
            chk($sformatf("R3 vec%0d gsh", i), s[0], VECS[i].e_gsh);
            chk($sformatf("R7 vec%0d hist", i), s[SW-1 -: HW], VECS[i].e_hist);
            resolve(s, VECS[i].taken, p != VECS[i].taken);
        end
        peek(10'h004); chk("R7 repaired hist", f_hist, 10'd92);

        // R2 / R8: bimodal saturation via snapshot-addressed updates
        do_reset();
        for (int k = 0; k < 3; k++) resolve(mk(0, 8'd20, 10'd500, 8'd200, 0, 0), 1, 0);
        resolve(mk(0, 8'd20, 10'd500, 8'd200, 0, 0), 0, 0);
        peek(10'd20); chk("R2 sat high", f_snap[1], 1); chk("R8 pred at idx 20", f_pred, 1);
        for (int k = 0; k < 4; k++) resolve(mk(0, 8'd20, 10'd500, 8'd200, 0, 0), 0, 0);
        resolve(mk(0, 8'd20, 10'd500, 8'd200, 0, 0), 1, 0);
        peek(10'd20); chk("R2 sat low", f_snap[1], 0);
        peek(10'd21); chk("R8 neighbour untouched", f_snap[1], 1);

        // R3 / R10: gshare index uses pc XOR history
        do_reset();
        resolve(mk(10'd2, 8'd100, 10'd700, 8'd100, 0, 0), 1, 1);
        peek(10'h0F0); chk("R7 set hist", f_hist, 10'd5);
        resolve(mk(10'd2, 8'd101, 10'h0F0, 8'd101, 0, 0), 0, 0);
        resolve(mk(10'd2, 8'd101, 10'h0F0, 8'd101, 0, 0), 0, 0);
        peek(10'h0F0); chk("R10 resolve keeps hist", f_hist, 10'd5);
        chk("R3 gsh fresh slot", f_snap[0], 1);
        peek(10'h0F5); chk("R3 gsh hit xor slot", f_snap[0], 0);
        repeat (3) @(negedge clk);
        peek(10'h0F5); chk("R10 idle keeps hist", f_hist, 10'd5);

        // R9: snapshot field layout
        peek(10'h1A5);
        chk("R9 gsh idx", f_snap[2+CW +: HW], 10'h1A5 ^ 10'd5);
        chk("R9 bim idx", f_snap[2+CW+HW +: BW], 8'hA5);
        chk("R9 cho idx", f_snap[2 +: CW], 8'hA5);
        chk("R9 hist field", f_snap[SW-1 -: HW], f_hist);

        // R4 / R5: chooser steering and saturation
        do_reset();
        for (int k = 0; k < 3; k++) resolve(mk(0, 8'd31, 10'd500, 8'd30, 0, 1), 1, 0);
        resolve(mk(0, 8'd32, 10'd30, 8'd31, 0, 0), 0, 0);
        resolve(mk(0, 8'd32, 10'd30, 8'd31, 0, 0), 0, 0);
        peek(10'd30);
        chk("R4 gshare picked", f_pred, 0);
        chk("R4 bim disagrees", f_snap[1], 1);
        resolve(mk(0, 8'd31, 10'd500, 8'd30, 1, 1), 1, 0);
        resolve(mk(0, 8'd31, 10'd500, 8'd30, 0, 0), 1, 0);
        peek(10'd30); chk("R5 both same holds", f_pred, 0);
        resolve(mk(0, 8'd31, 10'd500, 8'd30, 1, 0), 1, 0);
        peek(10'd30); chk("R5 one step from floor", f_pred, 0);
        resolve(mk(0, 8'd31, 10'd500, 8'd30, 1, 0), 1, 0);
        peek(10'd30); chk("R5 back to bimodal", f_pred, 1);

        // R4: history-indexed chooser variant (u1) against address-indexed (u0)
        do_reset();
        resolve(mk(0, 8'd50, 10'd600, 8'd7, 0, 1), 1, 0);
        resolve(mk(0, 8'd50, 10'd600, 8'd7, 0, 1), 1, 0);
        resolve(mk(0, 8'd40, 10'd601, 8'd9, 0, 0), 0, 0);
        resolve(mk(0, 8'd40, 10'd601, 8'd9, 0, 0), 0, 0);
        resolve(mk(10'd3, 8'd60, 10'd602, 8'd9, 0, 0), 1, 1);
        peek(10'd40);
        chk("R4 hist-indexed cho idx", f_snap1[2 +: CW], 8'd7);
        chk("R4 hist-indexed picks gshare", f_pred1, 1);
        chk("R4 pc-indexed picks bimodal", f_pred, 0);

        // R6: speculative shift with predicted direction
        do_reset();
        fetch(10'h000, s, p);
        peek(10'h000); chk("R6 first shift", f_hist, 10'd1);
        fetch(10'h000, s, p);
        peek(10'h000); chk("R6 second shift", f_hist, 10'd3);

        // R7: repair beats a same-cycle fetch
        @(negedge clk);
        f_valid = 1'b1; f_pc = 10'h001;
        r_valid = 1'b1; r_snap = mk(10'h2AA, 8'd70, 10'd800, 8'd70, 0, 0);
        r_taken = 1'b0; r_mispredict = 1'b1;
        @(negedge clk);
        f_valid = 1'b0; r_valid = 1'b0; r_mispredict = 1'b0;
        #1;
        chk("R7 repair priority", f_hist, 10'h154);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule